// File: doc/BRIEF.md
# Framed Packet Receiver with CRC-16 Check

This block sits behind a serial byte receiver and pulls framed packets out of the raw byte stream. It looks for a two-byte sync pattern. It takes the count byte that follows and forwards that many payload bytes downstream as they arrive. It then compares the two trailing check bytes against a CRC-16 that it computes on the fly. At the end of each packet it raises exactly one verdict: good or bad.

Bytes are offered one at a time with a valid strobe. Idle cycles between bytes are allowed anywhere. A separate abort input reports a line timeout or idle gap from the byte receiver. An abort inside a packet kills that packet. The parser always returns to sync hunting after a verdict or an abort, so a damaged packet costs at most the bytes up to the next sync pattern.

All outputs are registered. Each one appears in the cycle after the input cycle that caused it.

Top module: `frame_rx`

## Requirements
- R1: After reset all outputs are low and the parser is hunting for the first sync byte.
- R2: A packet starts only on the byte 0xAA followed at once by 0x55. Other bytes while hunting produce no output, and 0xAA followed by any byte other than 0x55 or 0xAA drops back to hunting.
- R3: While waiting for 0x55, another 0xAA keeps the parser waiting for 0x55, so the sequence AA AA 55 still synchronises.
- R4: The byte after the sync pattern is the payload length N (0 to 255). The next N accepted bytes are forwarded in order on data_o with data_valid_o, one cycle after each is offered. sop_o marks the first payload byte and eop_o marks the last.
- R5: The two bytes after the payload carry a CRC-16 with polynomial 0x1021 and initial value 0xFFFF. It is computed MSB-first over the length byte and the payload and sent high byte first. On a match, pkt_ok_o pulses for one cycle, in the cycle after the second check byte is offered.
- R6: On a CRC mismatch, pkt_bad_o pulses for one cycle at the same point instead, and pkt_ok_o stays low.
- R7: A length of 0 goes straight to the check bytes, with no data_valid_o, sop_o or eop_o.
- R8: abort_i during the length, payload or check bytes pulses pkt_bad_o in the next cycle and returns to hunting. abort_i while hunting produces no pulse and does clear a half-seen sync pattern.
- R9: Payloads up to 255 bytes are received intact, including a 48-byte payload (53-byte packet).
- R10: Cycles with valid_i low change nothing, so bytes may be spread out with arbitrary gaps.
- R11: After any verdict or abort, the next sync pattern starts a new packet. Bytes between packets are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Incoming stream byte |
| valid_i | input | 1 | byte_i is valid this cycle |
| abort_i | input | 1 | Line timeout or idle; aborts a packet in progress |
| data_o | output | 8 | Forwarded payload byte |
| data_valid_o | output | 1 | data_o holds a payload byte |
| sop_o | output | 1 | First payload byte of a packet |
| eop_o | output | 1 | Last payload byte of a packet |
| pkt_ok_o | output | 1 | One-cycle pulse: packet complete, CRC matched |
| pkt_bad_o | output | 1 | One-cycle pulse: CRC mismatch or aborted packet |

## Verification
Directed packets come first: a short good packet, the same packet with a flipped check bit, a zero-length packet, and the 48-byte and 255-byte sizes. Together these separate the CRC verdict from the payload path and from the length counter limits. Garbage and false sync patterns ahead of a good packet (a lone 0x55, 0xAA followed by a wrong byte, AA AA 55) show whether the sync hunter drops or holds its state correctly. Truncated packets and aborts during hunting check that an abort is reported only when a packet is open. A seeded random run then mixes lengths, corrupted check bytes, inter-packet garbage and idle gaps, comparing every forwarded byte and verdict with a CRC model in the bench.

// File: rtl/frm_pkg.sv
package frm_pkg;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned CRC_W  = 16;

  typedef enum logic [2:0] {
    ST_HUNT0,
    ST_HUNT1,
    ST_LEN,
    ST_BODY,
    ST_CRC_HI,
    ST_CRC_LO
  } frm_state_e;

  // byte-wide step, MSB first
  function automatic logic [CRC_W-1:0] crc_step(
    input logic [CRC_W-1:0]  crc,
    input logic [DATA_W-1:0] din,
    input logic [CRC_W-1:0]  poly
  );
    logic [CRC_W-1:0] r;
    r = crc ^ {din, {(CRC_W-DATA_W){1'b0}}};
    for (int i = 0; i < DATA_W; i++) begin
      r = r[CRC_W-1] ? ((r << 1) ^ poly) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/frm_crc.sv
module frm_crc
  import frm_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] INIT = 16'hFFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic [CRC_W-1:0]  crc_o
);

  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= INIT;
    end else if (start_i) begin
      crc_q <= crc_step(INIT, byte_i, POLY);
    end else if (step_i) begin
      crc_q <= crc_step(crc_q, byte_i, POLY);
    end
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/frm_ctrl.sv
module frm_ctrl
  import frm_pkg::*;
#(
  parameter logic [DATA_W-1:0] HDR0 = 8'hAA,
  parameter logic [DATA_W-1:0] HDR1 = 8'h55
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              valid_i,
  input  logic              abort_i,
  input  logic [CRC_W-1:0]  crc_i,
  output logic              crc_start_o,
  output logic              crc_step_o,
  output logic              pay_o,
  output logic              first_o,
  output logic              last_o,
  output logic              good_o,
  output logic              bad_o
);

  localparam int unsigned CNT_W = DATA_W;

  frm_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q;
  logic              first_q;
  logic [DATA_W-1:0] hi_q;
  logic              mid;

  assign mid = (state_q != ST_HUNT0) && (state_q != ST_HUNT1);

  always_comb begin
    state_d     = state_q;
    crc_start_o = 1'b0;
    crc_step_o  = 1'b0;
    pay_o       = 1'b0;
    first_o     = 1'b0;
    last_o      = 1'b0;
    good_o      = 1'b0;
    bad_o       = 1'b0;
    if (abort_i) begin
      bad_o   = mid;
      state_d = ST_HUNT0;
    end else if (valid_i) begin
      unique case (state_q)
        ST_HUNT0: if (byte_i == HDR0) state_d = ST_HUNT1;
        ST_HUNT1: begin
          if (byte_i == HDR1)      state_d = ST_LEN;
          else if (byte_i != HDR0) state_d = ST_HUNT0;
        end
        ST_LEN: begin
          crc_start_o = 1'b1;
          state_d     = (byte_i == '0) ? ST_CRC_HI : ST_BODY;
        end
        ST_BODY: begin
          pay_o      = 1'b1;
          crc_step_o = 1'b1;
          first_o    = first_q;
          last_o     = (cnt_q == CNT_W'(1));
          if (last_o) state_d = ST_CRC_HI;
        end
        ST_CRC_HI: state_d = ST_CRC_LO;
        ST_CRC_LO: begin
          state_d = ST_HUNT0;
          if ({hi_q, byte_i} == crc_i) good_o = 1'b1;
          else                         bad_o  = 1'b1;
        end
        default: state_d = ST_HUNT0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT0;
      cnt_q   <= '0;
      first_q <= 1'b0;
      hi_q    <= '0;
    end else begin
      state_q <= state_d;
      if (valid_i && !abort_i) begin
        if (state_q == ST_LEN) begin
          cnt_q   <= byte_i;
          first_q <= 1'b1;
        end
        if (state_q == ST_BODY) begin
          cnt_q   <= cnt_q - CNT_W'(1);
          first_q <= 1'b0;
        end
        if (state_q == ST_CRC_HI) hi_q <= byte_i;
      end
    end
  end

  a_r3_hdr0_repeat_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HUNT1 && valid_i && !abort_i && byte_i == HDR0) |=> state_q == ST_HUNT1);

  a_r4_body_count_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BODY) |-> cnt_q != '0);

  a_r8_abort_to_hunt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> state_q == ST_HUNT0);

  a_r10_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !abort_i) |=> $stable(state_q) && $stable(cnt_q));

endmodule

// File: rtl/frame_rx.sv
module frame_rx
  import frm_pkg::*;
#(
  parameter logic [7:0]  HDR0     = 8'hAA,
  parameter logic [7:0]  HDR1     = 8'h55,
  parameter logic [15:0] CRC_POLY = 16'h1021,
  parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] byte_i,
  input  logic       valid_i,
  input  logic       abort_i,
  output logic [7:0] data_o,
  output logic       data_valid_o,
  output logic       sop_o,
  output logic       eop_o,
  output logic       pkt_ok_o,
  output logic       pkt_bad_o
);

  logic             crc_start, crc_step;
  logic             pay, first, last, good, bad;
  logic [CRC_W-1:0] crc;

  frm_crc #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (crc_start),
    .step_i  (crc_step),
    .byte_i  (byte_i),
    .crc_o   (crc)
  );

  frm_ctrl #(.HDR0(HDR0), .HDR1(HDR1)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_i      (byte_i),
    .valid_i     (valid_i),
    .abort_i     (abort_i),
    .crc_i       (crc),
    .crc_start_o (crc_start),
    .crc_step_o  (crc_step),
    .pay_o       (pay),
    .first_o     (first),
    .last_o      (last),
    .good_o      (good),
    .bad_o       (bad)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o       <= '0;
      data_valid_o <= 1'b0;
      sop_o        <= 1'b0;
      eop_o        <= 1'b0;
      pkt_ok_o     <= 1'b0;
      pkt_bad_o    <= 1'b0;
    end else begin
      if (pay) data_o <= byte_i;
      data_valid_o <= pay;
      sop_o        <= first;
      eop_o        <= last;
      pkt_ok_o     <= good;
      pkt_bad_o    <= bad;
    end
  end

  a_r5_verdict_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pkt_ok_o && pkt_bad_o));

  a_r4_sop_has_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sop_o || eop_o) |-> data_valid_o);

  a_r6_verdict_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_ok_o || pkt_bad_o) |=> !pkt_ok_o);

  a_r7_no_data_with_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_ok_o |-> !data_valid_o);

endmodule

// File: tb/frame_rx_bench.sv
module frame_rx_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] byte_in = '0;
  logic       valid_in = 1'b0;
  logic       abort_in = 1'b0;
  logic [7:0] data;
  logic       dval, sop, eop, ok, bad;

  always #5 clk = ~clk;

  frame_rx u_frame_rx (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .byte_i       (byte_in),
    .valid_i      (valid_in),
    .abort_i      (abort_in),
    .data_o       (data),
    .data_valid_o (dval),
    .sop_o        (sop),
    .eop_o        (eop),
    .pkt_ok_o     (ok),
    .pkt_bad_o    (bad)
  );

  int checks = 0;
  int errors = 0;

  logic [7:0] pay [0:255];
  logic [7:0] got [0:299];
  int n_data, n_sop, n_eop, n_ok, n_bad, sop_idx, eop_idx;

  always @(negedge clk) begin
    if (rst_n) begin
      if (dval) begin
        if (n_data < 300) got[n_data] = data;
        if (sop) sop_idx = n_data;
        if (eop) eop_idx = n_data;
        n_data++;
      end
      if (sop) n_sop++;
      if (eop) n_eop++;
      if (ok)  n_ok++;
      if (bad) n_bad++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic clr();
    n_data = 0; n_sop = 0; n_eop = 0; n_ok = 0; n_bad = 0;
    sop_idx = -1; eop_idx = -1;
  endtask

  function automatic logic [15:0] ref_crc(input int len);
    logic [15:0] c;
    logic [7:0]  b;
    c = 16'hFFFF;
    for (int k = -1; k < len; k++) begin
      b = (k < 0) ? 8'(len) : pay[k];
      for (int j = 7; j >= 0; j--) begin
        logic fb;
        fb = c[15] ^ b[j];
        c  = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    end
    return c;
  endfunction

  task automatic put(input logic [7:0] b, input int gap);
    repeat (gap) @(negedge clk);
    @(negedge clk);
    byte_in  = b;
    valid_in = 1'b1;
    @(posedge clk);
    #1 valid_in = 1'b0;
  endtask

  task automatic do_abort();
    @(negedge clk);
    abort_in = 1'b1;
    @(posedge clk);
    #1 abort_in = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic fill(input int len);
    for (int i = 0; i < len; i++) pay[i] = 8'($urandom);
  endtask

  task automatic send_pkt(input int len, input bit corrupt, input int gmax);
    logic [15:0] c;
    c = ref_crc(len);
    if (corrupt) c = c ^ (16'h1 << $urandom_range(0, 15));
    put(8'hAA, $urandom_range(0, gmax));
    put(8'h55, $urandom_range(0, gmax));
    put(8'(len), $urandom_range(0, gmax));
    for (int i = 0; i < len; i++) put(pay[i], $urandom_range(0, gmax));
    put(c[15:8], $urandom_range(0, gmax));
    put(c[7:0],  $urandom_range(0, gmax));
  endtask

  task automatic verify(input string req, input int len, input bit good);
    int mism;
    mism = 0;
    chk(req, "payload count", n_data, len);
    for (int i = 0; i < len && i < n_data; i++) if (got[i] !== pay[i]) mism++;
    chk(req, "payload mismatches", mism, 0);
    chk(req, "ok pulses", n_ok, good ? 1 : 0);
    chk(req, "bad pulses", n_bad, good ? 0 : 1);
    chk(req, "sop count", n_sop, (len > 0) ? 1 : 0);
    chk(req, "eop count", n_eop, (len > 0) ? 1 : 0);
    if (len > 0) begin
      chk(req, "sop position", sop_idx, 0);
      chk(req, "eop position", eop_idx, len - 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=150000 exp=<150000 cycles");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    clr();
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset", {31'd0, dval | sop | eop | ok | bad}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "outputs after reset", {31'd0, dval | sop | eop | ok | bad}, 0);

    // R4 R5: short good packet, checking pulse timing directly
    clr(); fill(4);
    send_pkt(4, 1'b0, 0);
    @(negedge clk);
    chk("R5", "ok one cycle after last check byte", {31'd0, ok}, 1);
    settle();
    verify("R4", 4, 1'b1);

    // R6: corrupted check
    clr(); fill(6);
    send_pkt(6, 1'b1, 0); settle();
    verify("R6", 6, 1'b0);

    // R7: zero length
    clr();
    send_pkt(0, 1'b0, 0); settle();
    verify("R7", 0, 1'b1);

    // R2: false sync patterns before a good packet
    clr(); fill(5);
    put(8'h55, 0); put(8'hAA, 0); put(8'h00, 0); put(8'h12, 0); put(8'h55, 0);
    settle();
    chk("R2", "no output from garbage", n_data + n_ok + n_bad, 0);
    send_pkt(5, 1'b0, 0); settle();
    verify("R2", 5, 1'b1);

    // R3: AA AA 55
    clr(); fill(3);
    put(8'hAA, 0);
    send_pkt(3, 1'b0, 0); settle();
    verify("R3", 3, 1'b1);

    // R8: truncated packet, then R11 resync
    clr(); fill(10);
    put(8'hAA, 0); put(8'h55, 0); put(8'd10, 0);
    for (int i = 0; i < 3; i++) put(pay[i], 0);
    do_abort();
    @(negedge clk);
    chk("R8", "bad one cycle after abort", {31'd0, bad}, 1);
    settle();
    chk("R8", "truncated bytes forwarded", n_data, 3);
    chk("R8", "truncated bad pulses", n_bad, 1);
    chk("R8", "truncated no eop", n_eop, 0);
    clr(); fill(7);
    send_pkt(7, 1'b0, 0); settle();
    verify("R11", 7, 1'b1);

    // R8: abort while hunting clears half-seen sync
    clr();
    put(8'hAA, 0); do_abort();
    put(8'h55, 0); put(8'd2, 0); put(8'h01, 0); put(8'h02, 0);
    settle();
    chk("R8", "abort while hunting no pulse", n_bad + n_ok + n_data, 0);

    // R9: 48-byte and 255-byte payloads
    clr(); fill(48);
    send_pkt(48, 1'b0, 0); settle();
    verify("R9", 48, 1'b1);
    clr(); fill(255);
    send_pkt(255, 1'b0, 0); settle();
    verify("R9", 255, 1'b1);

    // R10: gaps between bytes
    clr(); fill(9);
    send_pkt(9, 1'b0, 4); settle();
    verify("R10", 9, 1'b1);

    // random mix (R4 R5 R6 R10 R11)
    for (int p = 0; p < 40; p++) begin
      int len, ng;
      bit cor;
      len = $urandom_range(0, 60);
      cor = ($urandom_range(0, 3) == 0);
      ng  = $urandom_range(0, 3);
      clr(); fill(len);
      for (int g = 0; g < ng; g++) begin
        logic [7:0] gb;
        gb = 8'($urandom);
        if (gb == 8'hAA) gb = 8'h00;
        put(gb, 0);
      end
      send_pkt(len, cor, 2); settle();
      verify(cor ? "R6" : "R5", len, !cor);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule